// File: doc/BRIEF.md
# Switchable-Endian Data Memory Access Unit

This unit sits between a 32-bit core and a byte-addressed RAM. It carries out data loads and stores of one, two or four bytes. It places each byte of the access on one of four RAM byte lanes according to the current data byte order. The order is little-endian after reset. Software switches it to big-endian by setting bit 5 of the upper machine status CSR (address 0x310). The unit owns that bit, serves reads and writes to that CSR, and acknowledges the read-only machine information and counter CSR addresses without acting on them.

A separate instruction-fetch read port always returns four bytes in little-endian order, whatever the mode bit says. Lane `k` of each RAM port refers to the byte at the port's address plus `k`. The external RAM returns read data combinationally and applies per-lane write enables at the clock edge. Any read that would touch a byte past the end of the RAM raises a sticky halt output, and the unit then stops serving accesses until reset.

Top module: `endian_mem_unit`

## Requirements
- R1: A CSR write to 0x310 sets the big-endian mode from bit 5 of the write data and discards all other bits. Reading 0x310 returns 0x0000_0020 when big-endian mode is on and 0 otherwise.
- R2: After reset the mode is little-endian, `halted` is 0, and `ld_valid`, `f_rvalid` and `ram_d_we` are 0.
- R3: In little-endian mode, byte i of an N-byte access (i=0 is the least significant byte) maps to address+i, for both loads and stores. The `d_size` encoding is 0 for one byte, 1 for two bytes, and 2 or 3 for four bytes.
- R4: In big-endian mode, byte i of an N-byte access maps to address+N-1-i, for both loads and stores. Loads return the value in the low 8·N bits, with the upper bits zero.
- R5: Single-byte loads and stores give identical results in both modes.
- R6: A store drives write enables on exactly the N lanes it addresses. Bytes next to the accessed range keep their values.
- R7: CSR addresses 0xF11–0xF15, 0x300, 0x301, 0xC00–0xC02 and 0xC80–0xC82 are acknowledged (`csr_ack`=1) and read as 0. Writes to them leave the mode unchanged. Any other address except 0x310 is not acknowledged.
- R8: A fetch at address A returns, one cycle later with `f_rvalid`=1, the little-endian word made of bytes A..A+3, regardless of the mode.
- R9: A mode change applies from the first data access presented after the clock edge that takes the CSR write. An access presented in the same cycle as the write still uses the old mode.
- R10: A load or fetch that touches any byte at or above RAM_BYTES produces no valid result and sets `halted` on the next edge. `halted` stays set until reset.
- R11: While `halted` is set, no write enables, load results or fetch results are produced. A store that touches a byte at or above RAM_BYTES writes nothing and does not halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_en | input | 1 | CSR access strobe |
| csr_we | input | 1 | CSR access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data (combinational) |
| csr_ack | output | 1 | Address is one handled by this unit |
| d_valid | input | 1 | Data access request |
| d_write | input | 1 | 1 = store, 0 = load |
| d_size | input | 2 | Access size code |
| d_addr | input | 32 | Data byte address |
| d_wdata | input | 32 | Store value, low 8·N bits used |
| ld_valid | output | 1 | Load result valid (one cycle after request) |
| ld_data | output | 32 | Zero-extended load result |
| f_valid | input | 1 | Fetch request |
| f_addr | input | 32 | Fetch byte address |
| f_rvalid | output | 1 | Fetch result valid |
| f_rdata | output | 32 | Fetched little-endian word |
| ram_d_addr | output | 32 | Data port base address to RAM |
| ram_d_we | output | 4 | Per-lane write enables |
| ram_d_wdata | output | 32 | Per-lane write bytes |
| ram_d_rdata | input | 32 | Per-lane read bytes |
| ram_f_addr | output | 32 | Fetch port base address to RAM |
| ram_f_rdata | input | 32 | Fetch port lane bytes |
| halted | output | 1 | Sticky out-of-bounds halt |

## Verification
Every size is stored and loaded at aligned and misaligned addresses in both modes. Each result is compared with a byte-image model kept in the bench, and single-byte loads around each store expose any lane written by mistake or with a swapped byte. CSR writes with every bit set, or with only bit 5 cleared, show whether neighbouring bits leak into the mode. Fetches made in big-endian mode, and a CSR write issued in the same cycle as a load, separate the fetch ordering and the switch timing from the data path. Accesses that just fit and accesses that cross the end of the RAM, for stores, loads and fetches, test the bounds check and the sticky halt.

// File: rtl/endian_mem_pkg.sv
package endian_mem_pkg;

    localparam int LANES = 4;
    localparam logic [11:0] CSR_ENDIAN_ADDR = 12'h310;
    localparam int ENDIAN_BIT = 5;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_WIDE = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic      valid;
        logic      write;
        acc_size_e size;
        logic [31:0] addr;
        logic [31:0] wdata;
    } data_req_t;

    function automatic logic [2:0] size_bytes(acc_size_e s);
        case (s)
            ACC_BYTE: return 3'd1;
            ACC_HALF: return 3'd2;
            default:  return 3'd4;
        endcase
    endfunction

    // Maps a value byte index to a RAM lane (and back: the mapping is its own inverse).
    function automatic logic [1:0] lane_of(logic [1:0] idx, logic [2:0] n, logic big);
        logic [2:0] rev;
        rev = n - 3'd1 - {1'b0, idx};
        return big ? rev[1:0] : idx;
    endfunction

    function automatic logic csr_is_readonly(logic [11:0] a);
        case (a)
            12'hF11, 12'hF12, 12'hF13, 12'hF14, 12'hF15,
            12'h300, 12'h301,
            12'hC00, 12'hC01, 12'hC02,
            12'hC80, 12'hC81, 12'hC82: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/endian_csr_port.sv
module endian_csr_port
    import endian_mem_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        csr_en,
    input  logic        csr_we,
    input  logic [11:0] csr_addr,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    output logic        csr_ack,
    output logic        big_mode
);
    logic hit_mode;
    logic hit_ro;

    assign hit_mode = (csr_addr == CSR_ENDIAN_ADDR);
    assign hit_ro   = csr_is_readonly(csr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            big_mode <= 1'b0;
        end else if (csr_en && csr_we && hit_mode) begin
            big_mode <= csr_wdata[ENDIAN_BIT];
        end
    end

    always_comb begin
        csr_rdata = '0;
        csr_ack   = 1'b0;
        if (csr_en) begin
            csr_ack = hit_mode || hit_ro;
            if (hit_mode) csr_rdata[ENDIAN_BIT] = big_mode;
        end
    end

    AST_MODE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
        csr_en && csr_we && hit_mode |=> big_mode == $past(csr_wdata[ENDIAN_BIT])); // R1

    AST_OTHER_WRITE_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
        csr_en && csr_we && !hit_mode |=> $stable(big_mode)); // R7

endmodule

// File: rtl/byte_lane_steer.sv
module byte_lane_steer
    import endian_mem_pkg::*;
(
    input  logic        big,
    input  acc_size_e   size,
    input  logic [31:0] st_value,
    input  logic [31:0] lane_rdata,
    output logic [31:0] lane_wdata,
    output logic [LANES-1:0] lane_mask,
    output logic [31:0] ld_value
);
    logic [2:0] nbytes;
    assign nbytes = size_bytes(size);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [1:0] src;
        assign src = lane_of(2'(k), nbytes, big);
        assign lane_mask[k]       = (3'(k) < nbytes);
        assign lane_wdata[8*k +: 8] = lane_mask[k] ? st_value[{src, 3'b000} +: 8] : 8'h00;
        assign ld_value[8*k +: 8]   = lane_mask[k] ? lane_rdata[{src, 3'b000} +: 8] : 8'h00;
    end

endmodule

// File: rtl/access_bounds.sv
module access_bounds #(
    parameter int RAM_BYTES = 65536
) (
    input  logic [31:0] addr,
    input  logic [2:0]  nbytes,
    output logic        oob
);
    localparam logic [32:0] LAST_BYTE = 33'(RAM_BYTES - 1);
    logic [32:0] top_byte;

    assign top_byte = {1'b0, addr} + {30'd0, nbytes} - 33'd1;
    assign oob      = (top_byte > LAST_BYTE);

endmodule

// File: rtl/endian_mem_unit.sv
module endian_mem_unit
    import endian_mem_pkg::*;
#(
    parameter int RAM_BYTES = 65536
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        csr_en,
    input  logic        csr_we,
    input  logic [11:0] csr_addr,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    output logic        csr_ack,
    input  logic        d_valid,
    input  logic        d_write,
    input  logic [1:0]  d_size,
    input  logic [31:0] d_addr,
    input  logic [31:0] d_wdata,
    output logic        ld_valid,
    output logic [31:0] ld_data,
    input  logic        f_valid,
    input  logic [31:0] f_addr,
    output logic        f_rvalid,
    output logic [31:0] f_rdata,
    output logic [31:0] ram_d_addr,
    output logic [3:0]  ram_d_we,
    output logic [31:0] ram_d_wdata,
    input  logic [31:0] ram_d_rdata,
    output logic [31:0] ram_f_addr,
    input  logic [31:0] ram_f_rdata,
    output logic        halted
);
    data_req_t   req;
    logic        big_mode;
    logic [2:0]  d_nbytes;
    logic        d_oob;
    logic        f_oob;
    logic [LANES-1:0] lane_mask;
    logic [31:0] steered_ld;
    logic        d_ok;
    logic        f_ok;

    assign req = '{valid: d_valid, write: d_write, size: acc_size_e'(d_size),
                   addr: d_addr, wdata: d_wdata};
    assign d_nbytes = size_bytes(req.size);

    endian_csr_port u_csr (
        .clk(clk), .rst(rst),
        .csr_en(csr_en), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_ack(csr_ack),
        .big_mode(big_mode)
    );

    byte_lane_steer u_steer (
        .big(big_mode), .size(req.size), .st_value(req.wdata),
        .lane_rdata(ram_d_rdata), .lane_wdata(ram_d_wdata),
        .lane_mask(lane_mask), .ld_value(steered_ld)
    );

    access_bounds #(.RAM_BYTES(RAM_BYTES)) u_dbound (
        .addr(req.addr), .nbytes(d_nbytes), .oob(d_oob)
    );

    access_bounds #(.RAM_BYTES(RAM_BYTES)) u_fbound (
        .addr(f_addr), .nbytes(3'd4), .oob(f_oob)
    );

    assign d_ok       = req.valid && !d_oob && !halted;
    assign f_ok       = f_valid && !f_oob && !halted;
    assign ram_d_addr = req.addr;
    assign ram_f_addr = f_addr;
    assign ram_d_we   = (d_ok && req.write) ? lane_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            halted   <= 1'b0;
            ld_valid <= 1'b0;
            ld_data  <= '0;
            f_rvalid <= 1'b0;
            f_rdata  <= '0;
        end else begin
            if (!halted && ((req.valid && !req.write && d_oob) || (f_valid && f_oob)))
                halted <= 1'b1;
            ld_valid <= d_ok && !req.write;
            if (d_ok && !req.write) ld_data <= steered_ld;
            f_rvalid <= f_ok;
            if (f_ok) f_rdata <= ram_f_rdata;
        end
    end

    AST_STORE_LANE_COUNT: assert property (@(posedge clk) disable iff (rst)
        d_valid && d_write && !d_oob && !halted |-> $countones(ram_d_we) == int'(d_nbytes)); // R6

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted); // R10

    AST_OOB_LOAD_DROPPED: assert property (@(posedge clk) disable iff (rst)
        d_valid && !d_write && d_oob |=> !ld_valid && halted); // R10

    AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        halted |-> ram_d_we == 4'b0000); // R11

    AST_FETCH_RETURNS: assert property (@(posedge clk) disable iff (rst)
        f_valid && !f_oob && !halted |=> f_rvalid); // R8

endmodule

// File: tb/endian_mem_unit_tb_top.sv
`timescale 1ns/1ps
module endian_mem_unit_tb_top;
    localparam int RB = 256;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        csr_en = 0, csr_we = 0;
    logic [11:0] csr_addr = 0;
    logic [31:0] csr_wdata = 0;
    logic [31:0] csr_rdata;
    logic        csr_ack;
    logic        d_valid = 0, d_write = 0;
    logic [1:0]  d_size = 0;
    logic [31:0] d_addr = 0, d_wdata = 0;
    logic        ld_valid;
    logic [31:0] ld_data;
    logic        f_valid = 0;
    logic [31:0] f_addr = 0;
    logic        f_rvalid;
    logic [31:0] f_rdata;
    logic [31:0] ram_d_addr, ram_d_wdata, ram_d_rdata, ram_f_addr, ram_f_rdata;
    logic [3:0]  ram_d_we;
    logic        halted;

    endian_mem_unit #(.RAM_BYTES(RB)) dut_i (.*);

    logic [7:0] ram [RB];
    logic [7:0] shadow [RB];

    always_comb begin
        for (int k = 0; k < 4; k++) begin
            ram_d_rdata[8*k +: 8] = ram[8'(ram_d_addr + 32'(k))];
            ram_f_rdata[8*k +: 8] = ram[8'(ram_f_addr + 32'(k))];
        end
    end

    always @(posedge clk) begin
        for (int k = 0; k < 4; k++)
            if (ram_d_we[k]) ram[8'(ram_d_addr + 32'(k))] <= ram_d_wdata[8*k +: 8];
    end

    int checks = 0;
    int fails = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic int nb(int sz);
        return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] exp_val(int a, int sz, bit big);
        logic [31:0] v = 0;
        int n = nb(sz);
        for (int i = 0; i < n; i++)
            v[8*i +: 8] = shadow[big ? a + n - 1 - i : a + i];
        return v;
    endfunction

    task automatic csr_write(logic [11:0] a, logic [31:0] v);
        @(negedge clk);
        csr_en = 1; csr_we = 1; csr_addr = a; csr_wdata = v;
        @(negedge clk);
        csr_en = 0; csr_we = 0;
    endtask

    task automatic csr_read(logic [11:0] a, output logic [31:0] v, output logic ack);
        @(negedge clk);
        csr_en = 1; csr_we = 0; csr_addr = a;
        #1;
        v = csr_rdata; ack = csr_ack;
        @(negedge clk);
        csr_en = 0;
    endtask

    task automatic do_store(int a, int sz, logic [31:0] v);
        @(negedge clk);
        d_valid = 1; d_write = 1; d_size = 2'(sz); d_addr = 32'(a); d_wdata = v;
        @(negedge clk);
        d_valid = 0; d_write = 0;
    endtask

    task automatic do_load(int a, int sz, output logic [31:0] v, output logic vld);
        @(negedge clk);
        d_valid = 1; d_write = 0; d_size = 2'(sz); d_addr = 32'(a);
        @(negedge clk);
        d_valid = 0;
        v = ld_data; vld = ld_valid;
    endtask

    task automatic do_fetch(int a, output logic [31:0] v, output logic vld);
        @(negedge clk);
        f_valid = 1; f_addr = 32'(a);
        @(negedge clk);
        f_valid = 0;
        v = f_rdata; vld = f_rvalid;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic vld, ack;
        int addrs [6] = '{0, 1, 2, 3, 5, 10};

        for (int i = 0; i < RB; i++) begin
            ram[i] = 8'((i * 37 + 11) & 255);
            shadow[i] = ram[i];
        end
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk("R2 halted", {31'd0, halted}, 0);
        chk("R2 ld_valid", {31'd0, ld_valid}, 0);
        chk("R2 f_rvalid", {31'd0, f_rvalid}, 0);
        chk("R2 we", {28'd0, ram_d_we}, 0);
        csr_read(12'h310, v, ack);
        chk("R2 mode reset", v, 0);

        for (int big = 0; big < 2; big++) begin
            csr_write(12'h310, big ? 32'h20 : 32'h0);
            csr_read(12'h310, v, ack);
            chk("R1 readback", v, big ? 32'h20 : 32'h0);
            for (int sz = 0; sz < 3; sz++) begin
                foreach (addrs[j]) begin
                    int a = addrs[j] + 16 * sz + 64 * big;
                    logic [31:0] sv = 32'hA1B2C3D4 ^ 32'(a * 32'h01010101);
                    do_load(a, sz, v, vld);
                    chk(big ? "R4 load" : "R3 load", v, exp_val(a, sz, big[0]));
                    do_store(a, sz, sv);
                    for (int i = 0; i < nb(sz); i++)
                        shadow[big ? a + nb(sz) - 1 - i : a + i] = sv[8*i +: 8];
                    for (int b = a - 1; b <= a + 4; b++) begin
                        if (b >= 0) begin
                            do_load(b, 0, v, vld);
                            chk(sz == 0 ? "R5 byte" : "R6 neighbour", v, {24'd0, shadow[b]});
                        end
                    end
                    do_load(a, 3, v, vld);
                    chk(big ? "R4 wide" : "R3 wide", v, exp_val(a, 2, big[0]));
                end
            end
        end

        csr_write(12'h310, 32'hFFFFFFFF);
        csr_read(12'h310, v, ack);
        chk("R1 all ones", v, 32'h20);
        csr_write(12'h310, 32'hFFFFFFDF);
        csr_read(12'h310, v, ack);
        chk("R1 bit5 clear", v, 32'h0);

        csr_write(12'h310, 32'h20);
        csr_write(12'h300, 32'h0);
        csr_write(12'hC81, 32'h0);
        csr_read(12'h310, v, ack);
        chk("R7 mode kept", v, 32'h20);
        csr_read(12'hF13, v, ack);
        chk("R7 ro ack", {31'd0, ack}, 1);
        chk("R7 ro data", v, 0);
        csr_read(12'h7C0, v, ack);
        chk("R7 unknown ack", {31'd0, ack}, 0);

        @(negedge clk);
        csr_en = 1; csr_we = 1; csr_addr = 12'h310; csr_wdata = 0;
        d_valid = 1; d_write = 0; d_size = 2; d_addr = 32'd8;
        @(negedge clk);
        csr_en = 0; csr_we = 0; d_valid = 0;
        chk("R9 same cycle old mode", ld_data, exp_val(8, 2, 1'b1));
        do_load(8, 2, v, vld);
        chk("R9 next access new mode", v, exp_val(8, 2, 1'b0));

        csr_write(12'h310, 32'h20);
        for (int a = 0; a < 7; a += 3) begin
            do_fetch(a, v, vld);
            chk("R8 fetch valid", {31'd0, vld}, 1);
            chk("R8 fetch LE", v, exp_val(a, 2, 1'b0));
        end
        do_fetch(RB - 4, v, vld);
        chk("R8 fetch at end", v, exp_val(RB - 4, 2, 1'b0));
        do_load(RB - 4, 2, v, vld);
        chk("R10 in-range end load valid", {31'd0, vld}, 1);

        @(negedge clk);
        d_valid = 1; d_write = 1; d_size = 2; d_addr = RB - 2; d_wdata = 32'h55667788;
        #1;
        chk("R11 oob store no we", {28'd0, ram_d_we}, 0);
        @(negedge clk);
        d_valid = 0; d_write = 0;
        chk("R11 oob store no halt", {31'd0, halted}, 0);
        do_load(RB - 2, 1, v, vld);
        chk("R11 oob store no change", v, exp_val(RB - 2, 1, 1'b1));

        do_load(RB - 3, 2, v, vld);
        chk("R10 oob load no valid", {31'd0, vld}, 0);
        chk("R10 halt set", {31'd0, halted}, 1);
        @(negedge clk);
        d_valid = 1; d_write = 1; d_size = 0; d_addr = 32'd4; d_wdata = 32'hEE;
        #1;
        chk("R11 halted no we", {28'd0, ram_d_we}, 0);
        @(negedge clk);
        d_valid = 0; d_write = 0;
        do_load(4, 0, v, vld);
        chk("R11 halted no load", {31'd0, vld}, 0);
        do_fetch(0, v, vld);
        chk("R11 halted no fetch", {31'd0, vld}, 0);
        chk("R10 halt sticky", {31'd0, halted}, 1);

        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        chk("R2 halt cleared", {31'd0, halted}, 0);
        do_load(4, 0, v, vld);
        chk("R11 halted store dropped", v, {24'd0, shadow[4]});
        csr_read(12'h310, v, ack);
        chk("R2 mode after reset", v, 0);
        do_fetch(RB - 1, v, vld);
        chk("R10 oob fetch no valid", {31'd0, vld}, 0);
        chk("R10 oob fetch halts", {31'd0, halted}, 1);

        finish_run();
    end
endmodule